// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block collects a vector of level-sensitive interrupt sources (96 by default), filters them through a per-source mask, and drives a single interrupt request line to a processor. The mask is arranged as 32-bit banks. Each bank is changed only through a pair of registers: one sets mask bits where a 1 is written, and the other clears them. Bits written as 0 are left as they are.

When an unmasked source is high and no earlier interrupt is still awaiting service, the controller latches the lowest-numbered such source as the current interrupt number and raises its request line. The line then stays high until software writes the acknowledge bit. After that the sources are sampled again, so a source that is still high is delivered again.

A software reset returns the controller to its power-on state over a fixed number of cycles, and a status bit reports when it has finished. A read-only revision register identifies the implementation. The register port is a simple 32-bit port with single-cycle writes and combinational reads.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, `irq_out` is low, the interrupt-number register (offset 0x40) reads 0 and the status register (offset 0x14) bit 0 reads 1.
- R2: Source n belongs to bank k = n/32 at bit n mod 32. Writing a word to the set register at offset 0x8C + 0x20·k sets the mask bits that are 1 in that word. A masked source never raises `irq_out`.
- R3: Writing a word to the clear register at offset 0x88 + 0x20·k clears the mask bits that are 1 in that word. In both registers, bits written as 0 keep their value. Reading either register returns the bank's current mask.
- R4: When `irq_out` is low, no soft reset is running and at least one unmasked source is high at a clock edge, `irq_out` is high from that edge on.
- R5: At delivery, offset 0x40 bits [6:0] hold the index of the lowest-numbered unmasked source that was high. The upper bits read 0.
- R6: Once `irq_out` is high it stays high until a write with bit 0 = 1 to offset 0x48, and it is low in the cycle after that write. A write with bit 0 = 0 has no effect.
- R7: Sources are level-sensitive. After an acknowledge, an unmasked source that is still high is delivered again one cycle later.
- R8: Writing bit 1 = 1 to offset 0x10 starts a soft reset. For the 4 cycles after that write, status bit 0 reads 0, and then it reads 1. Afterwards all mask bits are 1, `irq_out` is low and offset 0x40 reads 0.
- R9: Offset 0x00 reads {24'b0, major[3:0], minor[3:0]}, which is 0x21 by default. Offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_src | input | 96 | Level-sensitive interrupt sources |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A corrupted mask bit shows up either on the next read-back of its bank, or one cycle after its source goes high: `irq_out` rises when it should not, or stays low when it should rise. A wrong delivery state shows within one cycle, either as a request line that does not drop after an acknowledge or as a missing re-delivery of a source that is still high. A wrong priority pick or a fault in the soft-reset counter appears in the very next read of the interrupt-number register or the status register. The sweep therefore walks every source individually and spot-checks pairs of sources for the lowest-index rule.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: register offsets and widths shared by the banked interrupt controller.
// Assumes byte offsets on an 8-bit address and 32-bit data words.
package irq_ctrl_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_REV      = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SYSCFG   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SYSSTAT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CURNUM   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_ACK      = 8'h48;
    localparam int               OFS_BANK0    = 'h80;
    localparam int               BANK_STRIDE  = 'h20;
    localparam int               OFS_CLR_SUB  = 'h08;
    localparam int               OFS_SET_SUB  = 'h0C;

    localparam int SOFTRST_BIT = 1;
    localparam int DONE_BIT    = 0;
    localparam int ACK_BIT     = 0;

    // Decoded request for one register-port cycle.
    typedef struct packed {
        logic                  wr_en;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     data;
    } reg_req_t;
endpackage

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
// Module: irq_mask_bank
// Holds the mask bits of one bank. A set strobe ORs in the written word and
// a clear strobe removes the written ones. Assumes the two strobes are never
// active together (they come from distinct addresses). While busy is high the
// bank is forced fully masked.
module irq_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    // Mask register update: reset and soft reset mask all, else apply set/clear.
    always_ff @(posedge clk) begin
        if (!rst_n || busy)
            mask <= '1;
        else if (set_we)
            mask <= mask | wdata;
        else if (clr_we)
            mask <= mask & ~wdata;
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !busy) |=> ((mask & $past(wdata)) == $past(wdata)));
    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !busy) |=> ((mask & $past(wdata)) == '0));
    // R3
    zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_we || clr_we) && !busy) |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
    // R8
    rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (mask == '1));
endmodule

// File: rtl/irq_lowest_find.sv
`timescale 1ns/1ps
// Module: irq_lowest_find
// Finds the lowest set bit of a request vector. Purely combinational;
// assumes N fits in IDX_W bits.
module irq_lowest_find #(
    parameter int N     = 96,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_soft_reset.sv
`timescale 1ns/1ps
// Module: irq_soft_reset
// Runs a fixed-length software reset. A start pulse loads the counter, and
// busy stays high until it reaches zero. Starts that arrive while busy are ignored.
module irq_soft_reset #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYC + 1);
    logic [CNT_W-1:0] cnt;

    // Countdown: load on start when idle, decrement while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start && cnt == '0)
            cnt <= CNT_W'(CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
    assign busy = !done;

    // R8
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !done);
    // R8
    done_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

// File: rtl/irq_deliver.sv
`timescale 1ns/1ps
// Module: irq_deliver
// Delivery latch. When idle and a candidate exists, it captures the index and
// raises the request. The request is held until acknowledged. Assumes any and
// idx come from the same cycle's masked sources.
module irq_deliver #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             any,
    input  logic [IDX_W-1:0] idx,
    input  logic             ack,
    output logic             irq_out,
    output logic [IDX_W-1:0] cur_num
);
    // Deliver / hold / acknowledge state.
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            irq_out <= 1'b0;
            cur_num <= '0;
        end else if (irq_out) begin
            if (ack)
                irq_out <= 1'b0;
        end else if (any) begin
            irq_out <= 1'b1;
            cur_num <= idx;
        end
    end

    // R4
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && any && !busy) |=> irq_out);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack && !busy) |=> irq_out);
    // R6
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack) |=> !irq_out);
    // R5
    num_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !busy) |=> $stable(cur_num));
endmodule

// File: rtl/irq_bank_ctrl.sv
`timescale 1ns/1ps
// Module: irq_bank_ctrl (top)
// Banked level-sensitive interrupt controller with a register port. Decodes
// the register writes, keeps one mask bank per 32 sources, picks the lowest
// unmasked active source and drives a single request line held until
// acknowledged. Assumes NUM_SRC is a multiple of BANK_W and that all sources
// are already synchronous to clk.
module irq_bank_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int         NUM_SRC   = 96,
    parameter int         BANK_W    = 32,
    parameter int         RST_CYC   = 4,
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);
    localparam int NUM_BANKS = NUM_SRC / BANK_W;
    localparam int IDX_W     = $clog2(NUM_SRC);

    reg_req_t           req;
    logic [NUM_SRC-1:0] mask_all;
    logic [NUM_SRC-1:0] pend_vec;
    logic               busy, done, any;
    logic [IDX_W-1:0]   low_idx, cur_num;
    logic               ack, srst_start;

    // Register request bundle for this cycle.
    always_comb begin
        req.wr_en = reg_sel && reg_wr;
        req.addr  = reg_addr;
        req.data  = reg_wdata;
    end

    assign ack        = req.wr_en && req.addr == OFS_ACK && req.data[ACK_BIT];
    assign srst_start = req.wr_en && req.addr == OFS_SYSCFG && req.data[SOFTRST_BIT];

    // One mask bank per group of BANK_W sources.
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(OFS_BANK0 + k * BANK_STRIDE + OFS_SET_SUB);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(OFS_BANK0 + k * BANK_STRIDE + OFS_CLR_SUB);
        logic [BANK_W-1:0] bank_mask;

        irq_mask_bank #(.W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .busy   (busy),
            .set_we (req.wr_en && req.addr == SET_A),
            .clr_we (req.wr_en && req.addr == CLR_A),
            .wdata  (req.data[BANK_W-1:0]),
            .mask   (bank_mask)
        );
        assign mask_all[k*BANK_W +: BANK_W] = bank_mask;
    end

    assign pend_vec = irq_src & ~mask_all;

    irq_lowest_find #(.N(NUM_SRC), .IDX_W(IDX_W)) u_find (
        .req   (pend_vec),
        .found (any),
        .idx   (low_idx)
    );

    irq_soft_reset #(.CYC(RST_CYC)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (busy),
        .done  (done)
    );

    irq_deliver #(.IDX_W(IDX_W)) u_dlv (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .any     (any),
        .idx     (low_idx),
        .ack     (ack),
        .irq_out (irq_out),
        .cur_num (cur_num)
    );

    // Read multiplexer; offsets with no register return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_REV:     reg_rdata = DATA_W'({REV_MAJOR, REV_MINOR});
            OFS_SYSCFG:  reg_rdata[SOFTRST_BIT] = busy;
            OFS_SYSSTAT: reg_rdata[DONE_BIT] = done;
            OFS_CURNUM:  reg_rdata = DATA_W'(cur_num);
            default: begin
                for (int k = 0; k < NUM_BANKS; k++) begin
                    if (reg_addr == ADDR_W'(OFS_BANK0 + k * BANK_STRIDE + OFS_SET_SUB) ||
                        reg_addr == ADDR_W'(OFS_BANK0 + k * BANK_STRIDE + OFS_CLR_SUB))
                        reg_rdata = DATA_W'(mask_all[k*BANK_W +: BANK_W]);
                end
            end
        endcase
    end

    // R5
    pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ((($past(pend_vec) >> cur_num) & NUM_SRC'(1)) != '0));
    // R5
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> (($past(pend_vec) & ((NUM_SRC'(1) << cur_num) - NUM_SRC'(1))) == '0));
    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && pend_vec == '0) |=> !irq_out);
endmodule

// File: tb/irq_bank_ctrl_tb.sv
`timescale 1ns/1ps
module irq_bank_ctrl_tb;
    localparam int N = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] irq_src = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [3];
    bit finished = 0;

    irq_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_src(irq_src), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] set_a(int b);
        return 8'(8'h8C + 8'h20 * b);
    endfunction
    function automatic logic [7:0] clr_a(int b);
        return 8'(8'h88 + 8'h20 * b);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int b = 0; b < 3; b++) begin
            model[b] = 32'hFFFF_FFFF;
            rd(set_a(b), r); chk("R1 mask reset", r, 32'hFFFF_FFFF);
        end
        chk("R1 irq_out low", 32'(irq_out), 0);
        rd(8'h40, r); chk("R1 num zero", r, 0);
        rd(8'h14, r); chk("R1 status done", r, 1);
        // R9 revision and unused offsets
        rd(8'h00, r); chk("R9 revision", r, 32'h21);
        rd(8'h04, r); chk("R9 unused 0x04", r, 0);
        rd(8'h84, r); chk("R9 unused 0x84", r, 0);
        // R2 fully masked sources never deliver
        irq_src = '1;
        repeat (3) @(negedge clk);
        chk("R2 masked all quiet", 32'(irq_out), 0);
        irq_src = '0;

        // Sweep every source on its own
        for (int n = 0; n < N; n++) begin
            automatic int b = n / 32;
            automatic int bi = n % 32;
            wr(clr_a(b), 32'h1 << bi);
            model[b] = model[b] & ~(32'h1 << bi);
            rd(clr_a(b), r); chk("R3 mask after clear", r, model[b]);
            irq_src[n] = 1'b1;
            @(negedge clk);
            chk("R4 raise", 32'(irq_out), 1);
            rd(8'h40, r); chk("R5 R2 source number", r, n);
            wr(8'h48, 32'h0);
            chk("R6 zero ack holds", 32'(irq_out), 1);
            wr(8'h48, 32'h1);
            chk("R6 ack drops", 32'(irq_out), 0);
            @(negedge clk);
            chk("R7 level redelivers", 32'(irq_out), 1);
            wr(set_a(b), 32'h1 << bi);
            model[b] = model[b] | (32'h1 << bi);
            wr(8'h48, 32'h1);
            @(negedge clk);
            chk("R2 masked again quiet", 32'(irq_out), 0);
            rd(set_a(b), r); chk("R2 mask readback", r, model[b]);
            irq_src[n] = 1'b0;
        end

        // Lowest-index selection over pairs
        for (int b = 0; b < 3; b++) begin
            wr(clr_a(b), 32'hFFFF_FFFF);
            model[b] = 0;
        end
        for (int a = 0; a < N; a += 5) begin
            automatic int c = (a * 37 + 11) % N;
            automatic int lo = (a < c) ? a : c;
            irq_src = '0;
            wr(8'h48, 32'h1);
            irq_src[a] = 1'b1;
            irq_src[c] = 1'b1;
            @(negedge clk);
            rd(8'h40, r); chk("R5 lowest of pair", r, lo);
            irq_src = '0;
            wr(8'h48, 32'h1);
        end

        // R3 zero bits leave the mask unchanged
        wr(set_a(1), 32'h0000_00F0); model[1] = model[1] | 32'hF0;
        wr(set_a(1), 32'h0);
        rd(set_a(1), r); chk("R3 zero set keeps", r, model[1]);
        wr(clr_a(1), 32'h0);
        rd(clr_a(1), r); chk("R3 zero clear keeps", r, model[1]);
        wr(clr_a(1), 32'h0000_0030); model[1] = model[1] & ~32'h30;
        rd(set_a(1), r); chk("R3 partial clear", r, model[1]);

        // R8 soft reset sequence
        irq_src[40] = 1'b1;
        @(negedge clk);
        chk("R4 before soft reset", 32'(irq_out), 1);
        wr(8'h10, 32'h2);
        for (int i = 0; i < 4; i++) begin
            rd(8'h14, r); chk("R8 status busy", r, 0);
            @(negedge clk);
        end
        rd(8'h14, r); chk("R8 status done", r, 1);
        chk("R8 irq_out low", 32'(irq_out), 0);
        rd(8'h40, r); chk("R8 num cleared", r, 0);
        for (int b = 0; b < 3; b++) begin
            rd(set_a(b), r); chk("R8 masks set", r, 32'hFFFF_FFFF);
        end
        @(negedge clk);
        chk("R8 masked after soft reset", 32'(irq_out), 0);
        irq_src = '0;

        finish_run();
    end
endmodule